// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes incoming Ethernet frames as a byte stream and stores each one in a circular packet area of local RAM. The RAM is divided into 256-byte pages. The host sets the ring limits with a first page and an end page, where the end page is exclusive. A current-page pointer marks where the next frame will go. Before the first byte of a frame is stored, the block checks the worst-case free space between that pointer and a boundary page owned by the host. If the space is too small, the whole frame is dropped.

Each stored frame takes up a whole number of pages. Its payload starts four bytes into its first page. The block fills those four bytes with a link header (status, next-frame page, two length bytes) after the payload, because the length is known only when the last byte arrives. Short frames are padded with zeros up to the minimum frame size. Once the header is written, the current page moves to the link target and a sticky receive-done flag is raised. The flag stays set until the host clears it.

Top module: `rx_ring_writer`

## Requirements
- R1: Payload byte k of a frame is written to byte address (current page × 256) + 4 + k. The address is a page number shifted left by 8, and bytes past the ring end are placed as described in R8.
- R2: The free space is checked when the first byte of a frame arrives:
  - If current < boundary, free = (boundary − current) × 256.
  - Otherwise, free = ((end − first) − (current − boundary)) × 256.
  - If free is under 1518 bytes, the frame is dropped. No RAM write is made, the current page is unchanged and the done flag stays clear.
- R3: While the halt input is 1, every incoming frame is dropped, with the same effects as in R2.
- R4: A frame shorter than 60 bytes is stored with zero bytes appended up to 60 bytes. The stored size is then 60.
- R5: The four bytes at offsets 0, 1, 2 and 3 of the frame's first page hold, in that order:
  - the status byte;
  - the next-frame page;
  - the low byte of (stored size + 4);
  - the high byte of (stored size + 4).
- R6: The next-frame page is current + ((stored size + 8 + 255) div 256). If that page is at or beyond the end page, (end − first) is subtracted from it.
- R7: The status byte is 0x01 when bit 0 of the first frame byte is 0, and 0x21 when that bit is 1.
- R8: A payload byte that would land at (end page × 256) goes to (first page × 256) instead, and storing continues upward from there.
- R9: After the last header byte is written, the current page equals the next-frame page and rx_done reads 1. rx_done stays 1 until rx_done_clr is pulsed.
- R10: in_ready is low from the cycle after the last frame byte is accepted until all four header bytes have been written. In idle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| halt | input | 1 | Stop bit from the command register; drops all frames |
| pg_first | input | 8 | First page of the ring |
| pg_end | input | 8 | Page one past the last ring page |
| pg_bound | input | 8 | Boundary page owned by the host |
| cur_wr_en | input | 1 | Host load strobe for the current page |
| cur_wr_pg | input | 8 | Value for the host load |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_ready | output | 1 | Block can accept a byte |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| cur_page | output | 8 | Current-page pointer |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_done_clr | input | 1 | Clears rx_done |

## Verification
The hardest case to reach is a frame whose payload crosses the ring end while its link target also wraps. The bench gets there by loading the current page with the last ring page through the host load port. It then sends a 300-byte frame and checks three things: the byte that lands at the ring start, the wrapped link page, and the header bytes at the old page. The refusal thresholds are reached by placing the boundary exactly one page either side of the 1518-byte limit, once with the current page below the boundary and once with it above.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int PG_SHIFT = 8;
  localparam int LEN_W    = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_BODY, S_DROP, S_PAD, S_HDR
  } rxr_state_t;

  // Worst-case free bytes between the current page and the boundary.
  function automatic int free_bytes(int cur, int bnd, int first, int last_x);
    int pages;
    if (cur < bnd) pages = bnd - cur;
    else           pages = (last_x - first) - (cur - bnd);
    return pages * (1 << PG_SHIFT);
  endfunction

  // Page where the frame after this one will start.
  function automatic int link_page(int cur, int stored, int first, int last_x);
    int np;
    np = cur + ((stored + 8 + 255) >> PG_SHIFT);
    if (np >= last_x) np = np - (last_x - first);
    return np;
  endfunction
endpackage

// File: rtl/rxr_admit.sv
module rxr_admit #(
  parameter int PAGE_W  = 8,
  parameter int RESERVE = 1518
) (
  input  logic              halt_i,
  input  logic [PAGE_W-1:0] cur_i,
  input  logic [PAGE_W-1:0] bnd_i,
  input  logic [PAGE_W-1:0] first_i,
  input  logic [PAGE_W-1:0] end_i,
  output logic              ok_o
);
  import rxr_pkg::*;
  int room;
  always_comb begin
    room = free_bytes(int'(cur_i), int'(bnd_i), int'(first_i), int'(end_i));
    ok_o = !halt_i && (room >= RESERVE);
  end
endmodule

// File: rtl/rxr_link.sv
module rxr_link #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0]          cur_i,
  input  logic [PAGE_W-1:0]          first_i,
  input  logic [PAGE_W-1:0]          end_i,
  input  logic [rxr_pkg::LEN_W-1:0]  stored_i,
  output logic [PAGE_W-1:0]          next_pg_o,
  output logic [rxr_pkg::LEN_W-1:0]  hdr_len_o
);
  import rxr_pkg::*;
  always_comb begin
    next_pg_o = PAGE_W'(link_page(int'(cur_i), int'(stored_i),
                                  int'(first_i), int'(end_i)));
    hdr_len_o = stored_i + LEN_W'(4);
  end
endmodule

// File: rtl/rxr_ptr_step.sv
module rxr_ptr_step #(
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + rxr_pkg::PG_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] first_i,
  input  logic [PAGE_W-1:0] end_i,
  output logic [ADDR_W-1:0] addr_o
);
  import rxr_pkg::*;
  logic [ADDR_W-1:0] plus1;
  always_comb begin
    plus1  = addr_i + ADDR_W'(1);
    addr_o = (plus1 == {end_i, {PG_SHIFT{1'b0}}}) ? {first_i, {PG_SHIFT{1'b0}}} : plus1;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PAGE_W    = 8,
  parameter int MIN_FRAME = 60,
  parameter int RESERVE   = 1518,
  localparam int ADDR_W   = PAGE_W + rxr_pkg::PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic [PAGE_W-1:0] pg_first,
  input  logic [PAGE_W-1:0] pg_end,
  input  logic [PAGE_W-1:0] pg_bound,
  input  logic              cur_wr_en,
  input  logic [PAGE_W-1:0] cur_wr_pg,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic              rx_done,
  input  logic              rx_done_clr
);
  import rxr_pkg::*;
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [PG_SHIFT-1:0] HDR_SKIP = PG_SHIFT'(4);

  rxr_state_t        st;
  logic [ADDR_W-1:0] ptr, wr_addr, ptr_nx;
  logic [LEN_W-1:0]  cnt, cnt_nx, hdr_len;
  logic [1:0]        hidx;
  logic              mcast;
  logic [PAGE_W-1:0] next_pg;
  logic              admit_ok;
  logic [7:0]        hdr_byte;

  // Named events for the checker.
  logic accept_first, refused, pad_wr, hdr_phase, done_ev;

  rxr_admit #(.PAGE_W(PAGE_W), .RESERVE(RESERVE)) admit_i (
    .halt_i(halt), .cur_i(cur_page), .bnd_i(pg_bound),
    .first_i(pg_first), .end_i(pg_end), .ok_o(admit_ok));

  rxr_link #(.PAGE_W(PAGE_W)) link_i (
    .cur_i(cur_page), .first_i(pg_first), .end_i(pg_end),
    .stored_i(cnt), .next_pg_o(next_pg), .hdr_len_o(hdr_len));

  rxr_ptr_step #(.PAGE_W(PAGE_W)) step_i (
    .addr_i(wr_addr), .first_i(pg_first), .end_i(pg_end), .addr_o(ptr_nx));

  always_comb begin
    in_ready     = (st == S_IDLE) || (st == S_BODY) || (st == S_DROP);
    wr_addr      = (st == S_IDLE) ? {cur_page, HDR_SKIP} : ptr;
    cnt_nx       = cnt + LEN_W'(1);
    accept_first = (st == S_IDLE) && in_valid && admit_ok;
    refused      = (st == S_IDLE) && in_valid && !admit_ok;
    pad_wr       = (st == S_PAD);
    hdr_phase    = (st == S_HDR);
    done_ev      = (st == S_HDR) && (hidx == 2'd3);
    case (hidx)
      2'd0:    hdr_byte = mcast ? 8'h21 : 8'h01;
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = hdr_len[7:0];
      default: hdr_byte = hdr_len[15:8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; cnt <= '0; hidx <= '0; mcast <= 1'b0;
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      cur_page <= '0; rx_done <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      if (done_ev) rx_done <= 1'b1;
      else if (rx_done_clr) rx_done <= 1'b0;
      if (done_ev) cur_page <= next_pg;
      else if (cur_wr_en) cur_page <= cur_wr_pg;
      case (st)
        S_IDLE: begin
          if (accept_first) begin
            ram_we <= 1'b1; ram_addr <= wr_addr; ram_wdata <= in_data;
            ptr <= ptr_nx; cnt <= LEN_W'(1); mcast <= in_data[0];
            if (!in_last) st <= S_BODY;
            else          st <= (LEN_W'(1) < MIN_L) ? S_PAD : S_HDR;
          end else if (refused && !in_last) begin
            st <= S_DROP;
          end
          hidx <= '0;
        end
        S_BODY: begin
          if (in_valid) begin
            ram_we <= 1'b1; ram_addr <= wr_addr; ram_wdata <= in_data;
            ptr <= ptr_nx; cnt <= cnt_nx;
            if (in_last) st <= (cnt_nx < MIN_L) ? S_PAD : S_HDR;
          end
        end
        S_PAD: begin
          ram_we <= 1'b1; ram_addr <= wr_addr; ram_wdata <= 8'h00;
          ptr <= ptr_nx; cnt <= cnt_nx;
          if (cnt_nx >= MIN_L) st <= S_HDR;
        end
        S_HDR: begin
          ram_we <= 1'b1; ram_addr <= {cur_page, PG_SHIFT'(hidx)};
          ram_wdata <= hdr_byte;
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) st <= S_IDLE;
        end
        S_DROP: if (in_valid && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [7:0]        ram_wdata,
  input logic [PAGE_W-1:0] pg_first,
  input logic [PAGE_W-1:0] pg_end,
  input logic [PAGE_W-1:0] cur_page,
  input logic [PAGE_W-1:0] next_pg,
  input logic              hdr_phase,
  input logic              pad_wr,
  input logic              refused,
  input logic              done_ev
);
  p_ready_low_hdr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase |-> !in_ready);
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pad_wr |=> (ram_we && ram_wdata == 8'h00));
  p_refuse_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> !ram_we);
  p_write_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= {pg_first, 8'h00} && ram_addr < {pg_end, 8'h00}));
  p_cur_follows_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (cur_page == $past(next_pg)));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .ram_we(ram_we),
  .ram_addr(ram_addr), .ram_wdata(ram_wdata), .pg_first(pg_first),
  .pg_end(pg_end), .cur_page(cur_page), .next_pg(next_pg),
  .hdr_phase(hdr_phase), .pad_wr(pad_wr), .refused(refused), .done_ev(done_ev));

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 1'b0;
  logic [7:0] pg_first = 8'h10, pg_end = 8'h20, pg_bound = 8'h10;
  logic cur_wr_en = 1'b0; logic [7:0] cur_wr_pg = '0;
  logic in_valid = 1'b0; logic [7:0] in_data = '0; logic in_last = 1'b0;
  logic in_ready, ram_we, rx_done; logic rx_done_clr = 1'b0;
  logic [15:0] ram_addr; logic [7:0] ram_wdata, cur_page;

  int tests = 0, fails = 0, wr_cnt = 0;
  bit finished = 0;
  logic [7:0] mem [0:8191];

  always #5 clk = ~clk;

  rx_ring_writer dut_i (.clk(clk), .rst_n(rst_n), .halt(halt), .pg_first(pg_first),
    .pg_end(pg_end), .pg_bound(pg_bound), .cur_wr_en(cur_wr_en), .cur_wr_pg(cur_wr_pg),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cur_page(cur_page),
    .rx_done(rx_done), .rx_done_clr(rx_done_clr));

  always @(posedge clk) if (ram_we) begin
    mem[ram_addr[12:0]] <= ram_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  localparam int VEC_N = 6;
  localparam int VLEN [VEC_N] = '{64, 10, 60, 252, 248, 1};
  localparam int VB0  [VEC_N] = '{8'h00, 8'h01, 8'hFF, 8'h02, 8'h06, 8'h03};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k, int len, int b0);
    return (k == 0) ? 8'(b0) : 8'((k * 13 + len) & 255);
  endfunction

  task automatic set_cur(input logic [7:0] pg);
    @(negedge clk); cur_wr_en = 1'b1; cur_wr_pg = pg;
    @(negedge clk); cur_wr_en = 1'b0;
  endtask

  task automatic send(input int len, input int b0, output bit ready_after);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = pat(k, len, b0); in_last = (k == len - 1);
    end
    @(negedge clk);
    ready_after = in_ready;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_frame(input int len, input int b0, input logic [7:0] bnd);
    int cur0, stored, ln, nxt, base, a, wait_n;
    bit rdy, pay_ok;
    cur0 = int'(cur_page);
    pg_bound = bnd;
    wr_cnt = 0;
    stored = (len < 60) ? 60 : len;
    ln = stored + 4;
    nxt = cur0 + ((ln + 4 + 255) / 256);
    if (nxt >= 32) nxt = nxt - 16;
    send(len, b0, rdy);
    check(!rdy, "R10 ready low after last byte", int'(rdy), 0);
    wait_n = 0;
    while (!rx_done && wait_n < 400) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    check(rx_done == 1'b1, "R9 done flag set", int'(rx_done), 1);
    check(int'(cur_page) == nxt, "R6 R9 current page = link page", int'(cur_page), nxt);
    check(in_ready == 1'b1, "R10 ready back after header", int'(in_ready), 1);
    check(wr_cnt == stored + 4, "R4 write count", wr_cnt, stored + 4);
    base = cur0 * 256;
    check(int'(mem[base[12:0]]) == ((b0 & 1) ? 8'h21 : 8'h01), "R7 R5 status byte",
          int'(mem[base[12:0]]), (b0 & 1) ? 8'h21 : 8'h01);
    check(int'(mem[13'(base + 1)]) == nxt, "R5 next page byte", int'(mem[13'(base + 1)]), nxt);
    check(int'(mem[13'(base + 2)]) == (ln & 255), "R5 length low", int'(mem[13'(base + 2)]), ln & 255);
    check(int'(mem[13'(base + 3)]) == (ln >> 8), "R5 length high", int'(mem[13'(base + 3)]), ln >> 8);
    pay_ok = 1'b1;
    for (int k = 0; k < stored; k++) begin
      a = base + 4 + k;
      if (a >= 32 * 256) a = a - 16 * 256;
      if (mem[a[12:0]] != ((k < len) ? pat(k, len, b0) : 8'h00)) pay_ok = 1'b0;
    end
    check(pay_ok, "R1 R4 R8 payload and padding", int'(pay_ok), 1);
    @(negedge clk); rx_done_clr = 1'b1;
    @(negedge clk); rx_done_clr = 1'b0;
    check(rx_done == 1'b0, "R9 done flag cleared", int'(rx_done), 0);
  endtask

  task automatic refuse_case(input logic [7:0] cur, input logic [7:0] bnd, input string req);
    bit rdy;
    set_cur(cur);
    pg_bound = bnd;
    wr_cnt = 0;
    send(100, 8'h00, rdy);
    repeat (10) @(negedge clk);
    check(wr_cnt == 0, req, wr_cnt, 0);
    check(cur_page == cur, req, int'(cur_page), int'(cur));
    check(rx_done == 1'b0, req, int'(rx_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && rx_done == 1'b0 && ram_we == 1'b0 && cur_page == 8'h00,
          "R10 R9 reset state", {in_ready, rx_done, ram_we}, 3'b100);
    set_cur(8'h10);
    for (int v = 0; v < VEC_N; v++) run_frame(VLEN[v], VB0[v], cur_page);
    // R8 wrap of payload and of link page
    set_cur(8'h1F);
    run_frame(300, 8'h05, 8'h1F);
    check(mem[13'h1000] == pat(252, 300, 5), "R8 first wrapped byte at ring start",
          int'(mem[13'h1000]), int'(pat(252, 300, 5)));
    // R2 free-space limits
    refuse_case(8'h10, 8'h15, "R2 refuse below boundary (1280 bytes)");
    set_cur(8'h10);
    run_frame(100, 8'h00, 8'h16);
    refuse_case(8'h1B, 8'h10, "R2 refuse above boundary (1280 bytes)");
    // R3 halt drops frames
    halt = 1'b1;
    refuse_case(8'h10, 8'h10, "R3 halted drop");
    halt = 1'b0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule